// File: doc/BRIEF.md
# Dual Framebuffer Scanout Address Controller

This block sits in front of a display fetch engine that alternates between two framebuffer slots. Each slot is described by a base address and a ceiling address. A request carries the buffer address, the plane offset, the pitch, the pan position (x, y), the pixel size in bits and the number of active lines. The block latches these fields and computes the scanout window over a short staged sequence. The start is the buffer address plus the offset, plus y times the pitch, plus x times the pixel size in bytes. The end is the start plus the active lines times the pitch.

While the display is off, a computed window goes straight into both slots. While the display is on, the window is held as pending and each slot is marked dirty. Each slot then takes the new window at its own end-of-frame strobe, so the fetch engine never sees a slot change mid-frame. A request tagged as a flip also arms a completion event. That event fires once, on the first end-of-frame strobe of either slot. Only one flip may be outstanding at a time. When the status inputs report sync loss and FIFO underflow together, the block runs a stop, status-clear and restart sequence, and it ignores the end-of-frame work of that cycle.

Top module: `fb_scan_addr`

## Requirements
- R1: After reset, all four address outputs are zero and busy, flipDone, reqBusyReject, rasterStop, statusClear and rasterStart are low.
- R2: The computed start is reqBufAddr + reqOffset + reqY*reqPitch + reqX*(reqBpp/8), where reqBpp is in bits and the division truncates. All arithmetic is modulo 2^32.
- R3: The computed ceiling is start + reqLines*reqPitch.
- R4: With dispOn low, an accepted request writes the computed start/ceiling into both slot pairs and leaves busy low. The new values are visible no later than five clock cycles after the request cycle.
- R5: With dispOn high, an accepted request leaves both slot pairs unchanged and marks both slots dirty, so busy goes high.
- R6: An end-of-frame strobe on slot n (eof0 for slot 0, eof1 for slot 1) while slot n is dirty loads slot n from the pending window on the next edge and clears only that slot's dirty flag. Busy drops once both flags are clear.
- R7: An end-of-frame strobe on a slot whose dirty flag is clear changes neither slot pair and leaves the other slot's dirty flag, and so busy, unchanged.
- R8: A flip request (reqValid with reqIsFlip high) while a flip event is outstanding is dropped. reqBusyReject pulses for one cycle, and the dropped request never reaches the slot pairs.
- R9: An outstanding flip event produces exactly one flipDone pulse. The pulse comes one cycle after the first end-of-frame strobe of either slot. Later strobes produce no pulse.
- R10: When syncLost and fifoUnder are high in the same cycle, rasterStop and statusClear pulse in the next cycle and rasterStart pulses in the cycle after that. Any end-of-frame strobe in the error cycle loads nothing and signals no flip.
- R11: syncLost without fifoUnder starts no recovery, and end-of-frame handling proceeds normally in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqIsFlip | input | 1 | Request arms a flip-complete event |
| reqBufAddr | input | 32 | Buffer address |
| reqOffset | input | 32 | Plane offset in bytes |
| reqPitch | input | 16 | Bytes per line |
| reqX | input | 16 | Horizontal pan in pixels |
| reqY | input | 16 | Vertical pan in lines |
| reqBpp | input | 6 | Pixel size in bits |
| reqLines | input | 16 | Active lines |
| dispOn | input | 1 | Display enabled |
| eof0 | input | 1 | End-of-frame strobe, slot 0 |
| eof1 | input | 1 | End-of-frame strobe, slot 1 |
| syncLost | input | 1 | Sync-lost status |
| fifoUnder | input | 1 | FIFO-underflow status |
| base0 | output | 32 | Slot 0 base address |
| ceil0 | output | 32 | Slot 0 ceiling address |
| base1 | output | 32 | Slot 1 base address |
| ceil1 | output | 32 | Slot 1 ceiling address |
| busy | output | 1 | Any slot dirty |
| flipDone | output | 1 | Flip-complete pulse |
| reqBusyReject | output | 1 | Flip rejected pulse |
| rasterStop | output | 1 | Recovery stop pulse |
| statusClear | output | 1 | Recovery status-clear pulse |
| rasterStart | output | 1 | Recovery restart pulse |

## Verification
The end-of-frame retirement and the error recovery can fall in the same cycle. The bench provokes this with a flip outstanding and both slots dirty, then raises eof0 together with syncLost and fifoUnder. It judges that slot 0 holds its old window, that no flipDone appears, that busy stays high, and that the stop/clear pulse is followed by the restart pulse. A later clean strobe must then retire slot 0 and complete the flip. A strobe with only syncLost high checks that normal handling does not wait on the error path.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam int NBUF = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_SUM,
    ST_FIN,
    ST_APPLY
  } calcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic            latchReq;
    logic            doMul;
    logic            doSum;
    logic            doFin;
    logic            commit;
    logic            writeBoth;
    logic [NBUF-1:0] loadPair;
  } dpCtrl_t;
endpackage

// File: rtl/fb_scan_datapath.sv
module fb_scan_datapath
  import fb_scan_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 16,
  parameter int BPPW = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctl,
  input  logic [AW-1:0]            reqBufAddr,
  input  logic [AW-1:0]            reqOffset,
  input  logic [DW-1:0]            reqPitch,
  input  logic [DW-1:0]            reqX,
  input  logic [DW-1:0]            reqY,
  input  logic [BPPW-1:0]          reqBpp,
  input  logic [DW-1:0]            reqLines,
  output logic [NBUF-1:0][AW-1:0]  baseOut,
  output logic [NBUF-1:0][AW-1:0]  ceilOut
);
  localparam int BYW = BPPW - 3;

  logic [AW-1:0]  rBufAddr, rOffset;
  logic [DW-1:0]  rPitch, rX, rY, rLines;
  logic [BYW-1:0] rBytes;
  logic [AW-1:0]  yProd, xProd, lProd;
  logic [AW-1:0]  calcStart, calcEnd;
  logic [AW-1:0]  pendStart, pendEnd;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rBufAddr <= '0;
      rOffset  <= '0;
      rPitch   <= '0;
      rX       <= '0;
      rY       <= '0;
      rLines   <= '0;
      rBytes   <= '0;
    end else if (ctl.latchReq) begin
      rBufAddr <= reqBufAddr;
      rOffset  <= reqOffset;
      rPitch   <= reqPitch;
      rX       <= reqX;
      rY       <= reqY;
      rLines   <= reqLines;
      rBytes   <= reqBpp[BPPW-1:3];
    end
  end

  // staged arithmetic: products, then start, then end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yProd     <= '0;
      xProd     <= '0;
      lProd     <= '0;
      calcStart <= '0;
      calcEnd   <= '0;
    end else begin
      if (ctl.doMul) begin
        yProd <= AW'(rY) * AW'(rPitch);
        xProd <= AW'(rX) * AW'(rBytes);
        lProd <= AW'(rLines) * AW'(rPitch);
      end
      if (ctl.doSum) calcStart <= rBufAddr + rOffset + yProd + xProd;
      if (ctl.doFin) calcEnd   <= calcStart + lProd;
    end
  end

  // pending window, retired per slot later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendStart <= '0;
      pendEnd   <= '0;
    end else if (ctl.commit) begin
      pendStart <= calcStart;
      pendEnd   <= calcEnd;
    end
  end

  for (genvar n = 0; n < NBUF; n++) begin : g_pair
    logic [AW-1:0] bReg, cReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bReg <= '0;
        cReg <= '0;
      end else if (ctl.writeBoth) begin
        bReg <= calcStart;
        cReg <= calcEnd;
      end else if (ctl.loadPair[n]) begin
        bReg <= pendStart;
        cReg <= pendEnd;
      end
    end
    assign baseOut[n] = bReg;
    assign ceilOut[n] = cReg;

    AST_CEIL_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
      ctl.loadPair[n] && !ctl.writeBoth && (pendEnd >= pendStart)
      |=> (cReg >= bReg)); // R3
  end
endmodule

// File: rtl/fb_scan_control.sv
module fb_scan_control
  import fb_scan_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqIsFlip,
  input  logic    dispOn,
  input  logic    eof0,
  input  logic    eof1,
  input  logic    syncLost,
  input  logic    fifoUnder,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    flipDone,
  output logic    reqBusyReject,
  output logic    rasterStop,
  output logic    statusClear,
  output logic    rasterStart
);
  calcState_t      state, stateNxt;
  logic [NBUF-1:0] dirty;
  logic [NBUF-1:0] eofVec;
  logic            eventPending;
  logic            errNow;
  logic            rejectNow;
  logic            anyEof;
  logic            setDirty;

  assign eofVec    = {eof1, eof0};
  assign anyEof    = |eofVec;
  assign errNow    = syncLost && fifoUnder;
  assign rejectNow = reqValid && reqIsFlip && eventPending;
  assign setDirty  = (state == ST_APPLY) && dispOn;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    case (state)
      ST_IDLE: if (reqValid && !rejectNow) begin
        ctl.latchReq = 1'b1;
        stateNxt     = ST_MUL;
      end
      ST_MUL:  begin ctl.doMul = 1'b1; stateNxt = ST_SUM; end
      ST_SUM:  begin ctl.doSum = 1'b1; stateNxt = ST_FIN; end
      ST_FIN:  begin ctl.doFin = 1'b1; stateNxt = ST_APPLY; end
      ST_APPLY: begin
        ctl.commit    = 1'b1;
        ctl.writeBoth = !dispOn;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
    ctl.loadPair = errNow ? '0 : (dirty & eofVec);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      dirty         <= '0;
      eventPending  <= 1'b0;
      flipDone      <= 1'b0;
      reqBusyReject <= 1'b0;
      rasterStop    <= 1'b0;
      statusClear   <= 1'b0;
      rasterStart   <= 1'b0;
    end else begin
      state         <= stateNxt;
      reqBusyReject <= rejectNow;
      rasterStop    <= errNow;
      statusClear   <= errNow;
      rasterStart   <= rasterStop;
      // a fresh window outranks a retirement in the same cycle
      if (setDirty) dirty <= '1;
      else          dirty <= dirty & ~ctl.loadPair;
      flipDone <= 1'b0;
      if (ctl.latchReq && reqIsFlip) begin
        eventPending <= 1'b1;
      end else if (eventPending && anyEof && !errNow) begin
        eventPending <= 1'b0;
        flipDone     <= 1'b1;
      end
    end
  end

  assign busy = |dirty;

  AST_RESTART_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rasterStop |=> rasterStart); // R10
  AST_FLIP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    flipDone |=> !flipDone); // R9
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    reqBusyReject |-> $past(reqValid && reqIsFlip)); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(anyEof && !errNow)); // R6
endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr
  import fb_scan_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 16,
  parameter int BPPW = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqIsFlip,
  input  logic [AW-1:0]   reqBufAddr,
  input  logic [AW-1:0]   reqOffset,
  input  logic [DW-1:0]   reqPitch,
  input  logic [DW-1:0]   reqX,
  input  logic [DW-1:0]   reqY,
  input  logic [BPPW-1:0] reqBpp,
  input  logic [DW-1:0]   reqLines,
  input  logic            dispOn,
  input  logic            eof0,
  input  logic            eof1,
  input  logic            syncLost,
  input  logic            fifoUnder,
  output logic [AW-1:0]   base0,
  output logic [AW-1:0]   ceil0,
  output logic [AW-1:0]   base1,
  output logic [AW-1:0]   ceil1,
  output logic            busy,
  output logic            flipDone,
  output logic            reqBusyReject,
  output logic            rasterStop,
  output logic            statusClear,
  output logic            rasterStart
);
  dpCtrl_t                 ctl;
  logic [NBUF-1:0][AW-1:0] baseOut, ceilOut;

  fb_scan_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsFlip(reqIsFlip),
    .dispOn(dispOn), .eof0(eof0), .eof1(eof1), .syncLost(syncLost),
    .fifoUnder(fifoUnder), .ctl(ctl), .busy(busy), .flipDone(flipDone),
    .reqBusyReject(reqBusyReject), .rasterStop(rasterStop),
    .statusClear(statusClear), .rasterStart(rasterStart)
  );

  fb_scan_datapath #(.AW(AW), .DW(DW), .BPPW(BPPW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqBufAddr(reqBufAddr),
    .reqOffset(reqOffset), .reqPitch(reqPitch), .reqX(reqX), .reqY(reqY),
    .reqBpp(reqBpp), .reqLines(reqLines), .baseOut(baseOut), .ceilOut(ceilOut)
  );

  assign base0 = baseOut[0];
  assign ceil0 = ceilOut[0];
  assign base1 = baseOut[1];
  assign ceil1 = ceilOut[1];

  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    syncLost && fifoUnder && dispOn
    |=> $stable(base0) && $stable(ceil0) && $stable(base1) && $stable(ceil1)); // R10
endmodule

// File: tb/fb_scan_addr_tb_top.sv
`timescale 1ns/1ps
module fb_scan_addr_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqIsFlip = 0;
  logic [31:0] reqBufAddr = 0, reqOffset = 0;
  logic [15:0] reqPitch = 0, reqX = 0, reqY = 0, reqLines = 0;
  logic [5:0]  reqBpp = 0;
  logic        dispOn = 0, eof0 = 0, eof1 = 0, syncLost = 0, fifoUnder = 0;
  logic [31:0] base0, ceil0, base1, ceil1;
  logic        busy, flipDone, reqBusyReject, rasterStop, statusClear, rasterStart;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic lastReject;

  always #2 clk = ~clk;

  fb_scan_addr dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] calcS(logic [31:0] b, logic [31:0] o,
      int p, int x, int y, int bpp);
    return b + o + 32'(y * p) + 32'(x * (bpp / 8));
  endfunction

  // pulse a request, capture the reject pulse, then wait for the pipeline
  task automatic issue(bit flip, logic [31:0] b, logic [31:0] o,
      int p, int x, int y, int bpp, int lines);
    @(negedge clk);
    reqValid = 1; reqIsFlip = flip; reqBufAddr = b; reqOffset = o;
    reqPitch = 16'(p); reqX = 16'(x); reqY = 16'(y); reqBpp = 6'(bpp);
    reqLines = 16'(lines);
    @(negedge clk);
    lastReject = reqBusyReject;
    reqValid = 0; reqIsFlip = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe(bit e0, bit e1, bit sl, bit fu);
    @(negedge clk);
    eof0 = e0; eof1 = e1; syncLost = sl; fifoUnder = fu;
    @(negedge clk);
    eof0 = 0; eof1 = 0; syncLost = 0; fifoUnder = 0;
  endtask

  task automatic t_reset();
    chk("R1 base0", base0, 0);
    chk("R1 ceil0", ceil0, 0);
    chk("R1 base1", base1, 0);
    chk("R1 ceil1", ceil1, 0);
    chk("R1 pulses", {busy, flipDone, reqBusyReject, rasterStop, statusClear, rasterStart}, 0);
  endtask

  logic [31:0] sA, eA, sB, eB, sC, eC;

  task automatic t_off_write();
    dispOn = 0;
    sA = calcS(32'h1000_0000, 32'h40, 2560, 3, 2, 32);
    eA = sA + 32'(480 * 2560);
    issue(0, 32'h1000_0000, 32'h40, 2560, 3, 2, 32, 480);
    chk("R2 base0", base0, sA);
    chk("R3 ceil0", ceil0, eA);
    chk("R4 base1", base1, sA);
    chk("R4 ceil1", ceil1, eA);
    chk("R4 busy", busy, 0);
    sB = calcS(32'h8000_1000, 32'h0, 1600, 5, 7, 16);
    eB = sB + 32'(600 * 1600);
    issue(0, 32'h8000_1000, 32'h0, 1600, 5, 7, 16, 600);
    chk("R2 base1 bpp16", base1, sB);
    chk("R3 ceil1 bpp16", ceil1, eB);
  endtask

  task automatic t_on_dirty();
    dispOn = 1;
    sC = calcS(32'h2000_0000, 32'h100, 1280, 10, 20, 24);
    eC = sC + 32'(720 * 1280);
    issue(0, 32'h2000_0000, 32'h100, 1280, 10, 20, 24, 720);
    chk("R5 base0 held", base0, sB);
    chk("R5 ceil1 held", ceil1, eB);
    chk("R5 busy", busy, 1);
    strobe(0, 1, 0, 0);
    chk("R6 base1 load", base1, sC);
    chk("R6 ceil1 load", ceil1, eC);
    chk("R6 base0 other", base0, sB);
    chk("R6 busy one left", busy, 1);
    strobe(0, 1, 0, 0);
    chk("R7 clean eof busy", busy, 1);
    chk("R7 clean eof base0", base0, sB);
    strobe(1, 0, 0, 0);
    chk("R6 base0 load", base0, sC);
    chk("R6 busy clear", busy, 0);
  endtask

  logic [31:0] sD, eD;
  task automatic t_flip();
    dispOn = 1;
    sD = calcS(32'h3000_0000, 32'h0, 4096, 1, 1, 32);
    eD = sD + 32'(1080 * 4096);
    issue(1, 32'h3000_0000, 32'h0, 4096, 1, 1, 32, 1080);
    chk("R8 first flip ok", lastReject, 0);
    issue(1, 32'h4000_0000, 32'h0, 4096, 0, 0, 32, 10);
    chk("R8 second flip reject", lastReject, 1);
    chk("R8 reject one cycle", reqBusyReject, 0);
    strobe(1, 0, 0, 0);
    chk("R9 flipDone", flipDone, 1);
    chk("R8 dropped req base0", base0, sD);
    @(negedge clk);
    chk("R9 single pulse", flipDone, 0);
    strobe(0, 1, 0, 0);
    chk("R9 no second pulse", flipDone, 0);
    chk("R8 dropped req ceil1", ceil1, eD);
  endtask

  logic [31:0] sF;
  task automatic t_error();
    dispOn = 1;
    sF = calcS(32'h5000_0000, 32'h20, 800, 4, 4, 16);
    issue(1, 32'h5000_0000, 32'h20, 800, 4, 4, 16, 480);
    strobe(1, 0, 1, 1);
    chk("R10 stop", rasterStop, 1);
    chk("R10 clear", statusClear, 1);
    chk("R10 no flip", flipDone, 0);
    chk("R10 base0 held", base0, sD);
    chk("R10 busy", busy, 1);
    @(negedge clk);
    chk("R10 start", rasterStart, 1);
    chk("R10 stop gone", rasterStop, 0);
    strobe(1, 0, 1, 0);
    chk("R11 no stop", rasterStop, 0);
    chk("R11 flip", flipDone, 1);
    chk("R11 base0 load", base0, sF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_off_write();
    t_on_dirty();
    t_flip();
    t_error();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule